// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit side of an Ethernet controller's buffer management. Software builds a ring of 8-byte transmit descriptors in memory, each pointing at one data buffer, then writes an activate register. The walker fetches descriptors one after another over a simple word-wide memory request port. It reads the buffer bytes each descriptor names and streams them on a byte-wide output with a last-byte marker. It returns every descriptor to software by writing its flags back with the ready bit cleared. One frame may span several descriptors, and a wrap flag sends the walk back to the programmed ring start.

Frames longer than a fixed maximum are cut short, and a babble event is raised. Three one-cycle event pulses tell the surrounding controller that a buffer was consumed, that a frame was finished, or that a frame was truncated. Line coding, collision handling and CRC generation belong to the MAC that consumes the byte stream.

Top module: `txr_ring_walker`

## Requirements
- R1: A descriptor at byte address D is read as two 32-bit words. The word at D carries flags in bits 31:16 and the buffer length in bits 15:0. The word at D+4 is the buffer byte address. Every memory request uses a word-aligned address. Within a word, the byte at address A sits in bits 31-8*A[1:0] down to 24-8*A[1:0].
- R2: Flag bit 15 is ready, bit 13 is wrap and bit 11 is last. A fetched descriptor whose ready bit is clear ends the walk: it is neither written nor streamed.
- R3: Each processed descriptor gets one memory write of its header word to D. The write carries the fetched flags with bit 15 cleared and the fetched length. ev_txb pulses for one cycle in the cycle after that write is acknowledged.
- R4: The bytes of successive descriptors are streamed in order, with no gap in content. tx_last is high only on the final byte of a descriptor that has the last flag set. ev_txf pulses together with that descriptor's ev_txb. A last descriptor that contributes no bytes gives no marker.
- R5: A frame carries at most MAX_FRAME bytes (2032 by default). The descriptor that would cross this limit contributes only the bytes up to it, and ev_babt pulses once. The byte count restarts after each last descriptor and at each activation.
- R6: After a descriptor, the next address is the ring start when its wrap flag is set. Otherwise it is the current address plus 8.
- R7: A write to the ring start register stores the value with its two low bits cleared. When no walk is running, it also sets the address of the next descriptor to fetch.
- R8: Register writes select by reg_sel: 0 is control, 1 is ring start, 2 is activate. Control bit 1 is the enable. An activate write while the enable is clear does nothing.
- R9: One activation processes at most MAX_DESC descriptors. The next activation resumes at the descriptor that follows the last one processed.
- R10: While tx_ready is low, tx_data and tx_last hold and no byte is lost. A memory request holds its address and type until mem_ready.
- R11: After reset the enable is clear, and mem_req, tx_valid and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 ring start, 2 activate |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (descriptor header) |
| mem_ready | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_last | output | 1 | Byte is the final byte of a frame |
| tx_ready | input | 1 | Byte sink accepts the byte |
| ev_txb | output | 1 | Pulse: a descriptor was handed back |
| ev_txf | output | 1 | Pulse: a frame was completed |
| ev_babt | output | 1 | Pulse: a frame was truncated |

## Verification
Memory requests are decoded from state registers. The request is accepted on the edge where mem_ready is high, and the next request can appear one cycle later. The first byte of a data word is valid one cycle after that word's read is acknowledged. The event pulses appear one cycle after the acknowledge of the write-back or header read that causes them. The bench records handshakes and pulses on the falling edge, when every one of these signals is settled, and it counts each pulse exactly once. It compares the stream, the event counts and the written-back memory only after the ports have stayed quiet for 20 cycles, so no check depends on when a walk ends.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_STRIDE = 8;
  localparam int PTR_OFFSET  = 4;
  localparam int FLAG_READY  = 15;
  localparam int FLAG_WRAP   = 13;
  localparam int FLAG_LAST   = 11;
  localparam int CTRL_EN_BIT = 1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_ACT  = 2'd2
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_DATA,
    ST_STREAM,
    ST_WB
  } walk_state_e;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
  } desc_hdr_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          ctrl_en,
  output logic          act_req,
  output logic          base_ld,
  output logic [AW-1:0] base_wval,
  output logic [AW-1:0] base_addr
);
  import txr_pkg::*;

  logic unused_bits;

  assign act_req   = reg_we && (reg_sel == SEL_ACT);
  assign base_ld   = reg_we && (reg_sel == SEL_BASE);
  assign base_wval = {reg_wdata[AW-1:2], 2'b00};
  assign unused_bits = ^{reg_wdata[0], reg_wdata >> AW};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      base_addr <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_CTRL) ctrl_en <= reg_wdata[CTRL_EN_BIT];
      if (base_ld) base_addr <= base_wval;
    end
  end
endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [1:0]  first,
  input  logic [2:0]  count,
  input  logic        mark,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  output logic        done
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  left_q;
  logic        mark_q;

  function automatic logic [7:0] byte_at(input logic [31:0] w, input logic [1:0] idx);
    logic [31:0] sh;
    sh = w << {idx, 3'b000};
    return sh[31:24];
  endfunction

  assign done = tx_valid && tx_ready && (left_q == 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      idx_q    <= '0;
      left_q   <= '0;
      mark_q   <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end else if (load) begin
      word_q   <= word;
      idx_q    <= first;
      left_q   <= count;
      mark_q   <= mark;
      tx_data  <= byte_at(word, first);
      tx_valid <= 1'b1;
      tx_last  <= mark && (count == 3'd1);
    end else if (tx_valid && tx_ready) begin
      if (left_q == 3'd1) begin
        tx_valid <= 1'b0;
        tx_last  <= 1'b0;
      end else begin
        idx_q   <= idx_q + 2'd1;
        left_q  <= left_q - 3'd1;
        tx_data <= byte_at(word_q, idx_q + 2'd1);
        tx_last <= mark_q && (left_q == 3'd2);
      end
    end
  end
endmodule

// File: rtl/txr_walker.sv
module txr_walker #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          base_ld,
  input  logic [AW-1:0] base_wval,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          lane_load,
  output logic [31:0]   lane_word,
  output logic [1:0]    lane_first,
  output logic [2:0]    lane_count,
  output logic          lane_mark,
  input  logic          lane_done,
  output logic          ev_txb,
  output logic          ev_txf,
  output logic          ev_babt,
  output logic          busy
);
  import txr_pkg::*;

  localparam int FW = $clog2(MAX_FRAME + 1);
  localparam int DW = $clog2(MAX_DESC + 1);

  walk_state_e   state;
  logic [AW-1:0] cur;
  logic [AW-1:0] bptr;
  logic [15:0]   flags_q;
  logic [15:0]   len_q;
  logic [FW-1:0] rem;
  logic [FW-1:0] fc;
  logic [DW-1:0] dcnt;
  logic [2:0]    n_q;

  desc_hdr_t     hdr;
  logic [16:0]   sum;
  logic          over;
  logic [FW-1:0] take;
  logic [1:0]    off;
  logic [2:0]    avail;
  logic [2:0]    chunk;
  logic [15:0]   fl_back;
  logic [AW-1:0] nxt_ptr;
  logic          unused_bits;

  assign hdr   = mem_rdata;
  assign sum   = 17'(fc) + 17'(hdr.len);
  assign over  = sum > 17'(MAX_FRAME);
  assign take  = over ? (FW'(MAX_FRAME) - fc) : FW'(hdr.len);
  assign off   = bptr[1:0];
  assign avail = 3'd4 - {1'b0, off};
  assign chunk = (rem < FW'(avail)) ? rem[2:0] : avail;
  assign nxt_ptr = flags_q[FLAG_WRAP] ? base_addr : cur + AW'(DESC_STRIDE);
  assign unused_bits = ^{mem_rdata >> AW};

  always_comb begin
    fl_back = flags_q;
    fl_back[FLAG_READY] = 1'b0;
  end

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_HDR) || (state == ST_PTR) ||
                     (state == ST_DATA) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_wdata = {fl_back, len_q};

  always_comb begin
    case (state)
      ST_PTR:  mem_addr = cur + AW'(PTR_OFFSET);
      ST_DATA: mem_addr = {bptr[AW-1:2], 2'b00};
      default: mem_addr = cur;
    endcase
  end

  assign lane_load  = (state == ST_DATA) && mem_ready;
  assign lane_word  = mem_rdata;
  assign lane_first = off;
  assign lane_count = chunk;
  assign lane_mark  = flags_q[FLAG_LAST] && (rem == FW'(chunk));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cur     <= '0;
      bptr    <= '0;
      flags_q <= '0;
      len_q   <= '0;
      rem     <= '0;
      fc      <= '0;
      dcnt    <= '0;
      n_q     <= '0;
      ev_txb  <= 1'b0;
      ev_txf  <= 1'b0;
      ev_babt <= 1'b0;
    end else begin
      ev_txb  <= 1'b0;
      ev_txf  <= 1'b0;
      ev_babt <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (base_ld) cur <= base_wval;
          if (start) begin
            fc    <= '0;
            dcnt  <= '0;
            state <= ST_HDR;
          end
        end
        ST_HDR: if (mem_ready) begin
          if (!hdr.flags[FLAG_READY]) begin
            state <= ST_IDLE;
          end else begin
            flags_q <= hdr.flags;
            len_q   <= hdr.len;
            rem     <= take;
            fc      <= fc + take;
            ev_babt <= over;
            state   <= ST_PTR;
          end
        end
        ST_PTR: if (mem_ready) begin
          bptr  <= mem_rdata[AW-1:0];
          state <= (rem == '0) ? ST_WB : ST_DATA;
        end
        ST_DATA: if (mem_ready) begin
          n_q   <= chunk;
          state <= ST_STREAM;
        end
        ST_STREAM: if (lane_done) begin
          bptr  <= bptr + AW'(n_q);
          rem   <= rem - FW'(n_q);
          state <= (rem == FW'(n_q)) ? ST_WB : ST_DATA;
        end
        ST_WB: if (mem_ready) begin
          ev_txb <= 1'b1;
          ev_txf <= flags_q[FLAG_LAST];
          if (flags_q[FLAG_LAST]) fc <= '0;
          cur   <= nxt_ptr;
          dcnt  <= dcnt + DW'(1);
          state <= (dcnt + DW'(1) == DW'(MAX_DESC)) ? ST_IDLE : ST_HDR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_ring_walker.sv
module txr_ring_walker #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032,
  parameter int MAX_DESC  = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          ev_txb,
  output logic          ev_txf,
  output logic          ev_babt
);
  logic          ctrl_en;
  logic          act_req;
  logic          base_ld;
  logic [AW-1:0] base_wval;
  logic [AW-1:0] base_addr;
  logic          walk_busy;
  logic          lane_load;
  logic [31:0]   lane_word;
  logic [1:0]    lane_first;
  logic [2:0]    lane_count;
  logic          lane_mark;
  logic          lane_done;

  txr_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_en(ctrl_en), .act_req(act_req),
    .base_ld(base_ld), .base_wval(base_wval), .base_addr(base_addr)
  );

  txr_walker #(.AW(AW), .MAX_FRAME(MAX_FRAME), .MAX_DESC(MAX_DESC)) walk_i (
    .clk(clk), .rst(rst), .start(act_req && ctrl_en),
    .base_addr(base_addr), .base_ld(base_ld), .base_wval(base_wval),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .lane_load(lane_load), .lane_word(lane_word), .lane_first(lane_first),
    .lane_count(lane_count), .lane_mark(lane_mark), .lane_done(lane_done),
    .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt), .busy(walk_busy)
  );

  txr_byte_lane lane_i (
    .clk(clk), .rst(rst), .load(lane_load), .word(lane_word),
    .first(lane_first), .count(lane_count), .mark(lane_mark),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .done(lane_done)
  );
endmodule

// File: rtl/txr_ring_walker_chk.sv
module txr_ring_walker_chk #(
  parameter int AW       = 32,
  parameter int MAX_DESC = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          wb_ready_bit,
  input logic          mem_ready,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          ev_txb,
  input logic          ev_txf,
  input logic          ctrl_en,
  input logic          act_req,
  input logic          walk_busy
);
  localparam int CW = $clog2(MAX_DESC + 2);

  logic [CW-1:0] wb_cnt;

  always_ff @(posedge clk) begin
    if (rst) wb_cnt <= '0;
    else if (!walk_busy && !ev_txb) wb_cnt <= '0;
    else if (ev_txb) wb_cnt <= wb_cnt + CW'(1);
  end

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_wb_clears_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !wb_ready_bit);

  p_frame_with_buf_r4: assert property (@(posedge clk) disable iff (rst)
    ev_txf |-> ev_txb);

  p_disabled_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (act_req && !ctrl_en && !walk_busy) |=> !walk_busy);

  p_desc_cap_r9: assert property (@(posedge clk) disable iff (rst)
    wb_cnt <= CW'(MAX_DESC));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_byte_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

bind txr_ring_walker txr_ring_walker_chk #(.AW(AW), .MAX_DESC(MAX_DESC)) chk_i (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .wb_ready_bit(mem_wdata[31]), .mem_ready(mem_ready), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready), .ev_txb(ev_txb),
  .ev_txf(ev_txf), .ctrl_en(ctrl_en), .act_req(act_req), .walk_busy(walk_busy)
);

// File: tb/txr_ring_walker_tb.sv
`timescale 1ns/1ps
module txr_ring_walker_tb_top;
  localparam int MAXD = 4;
  localparam int LAT  = 1;
  localparam int WD   = 20000;

  typedef struct packed {
    logic [15:0] len;
    logic [1:0]  off;
    logic        bp;
    logic        babt;
    logic [11:0] exp_n;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd1,    2'd0, 1'b0, 1'b0, 12'd1},
    '{16'd4,    2'd1, 1'b1, 1'b0, 12'd4},
    '{16'd7,    2'd3, 1'b0, 1'b0, 12'd7},
    '{16'd13,   2'd2, 1'b1, 1'b0, 12'd13},
    '{16'd0,    2'd0, 1'b0, 1'b0, 12'd0},
    '{16'd2040, 2'd0, 1'b1, 1'b1, 12'd2032}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, ev_txb, ev_txf, ev_babt;
  logic        tx_ready = 1'b1;

  logic [31:0] mem [0:1023];
  logic [7:0]  cap_d [0:4095];
  logic        cap_l [0:4095];
  int ncap, n_txb, n_txf, n_babt, n_rd, cyc;
  logic [31:0] first_rd, last_rd;
  int wcnt;
  bit bp_mode = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  txr_ring_walker #(.MAX_DESC(MAXD)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .ev_txb(ev_txb), .ev_txf(ev_txf), .ev_babt(ev_babt)
  );

  // memory responder: acknowledges each request LAT+1 cycles after it appears
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
      wcnt <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == LAT) begin
        mem_ready <= 1'b1;
        wcnt <= 0;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[11:2]];
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // monitor: sink pacing, byte capture, event and read recording
  always @(negedge clk) begin
    cyc++;
    tx_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    if (!rst) begin
      if (tx_valid && tx_ready) begin
        cap_d[ncap] = tx_data;
        cap_l[ncap] = tx_last;
        ncap++;
      end
      if (ev_txb) n_txb++;
      if (ev_txf) n_txf++;
      if (ev_babt) n_babt++;
      if (mem_req && mem_ready && !mem_we) begin
        if (n_rd == 0) first_rd = mem_addr;
        last_rd = mem_addr;
        n_rd++;
      end
    end
  end

  function automatic logic [7:0] eb(input int a);
    logic [31:0] v;
    v = a;
    return v[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) mem[i] = {eb(4*i), eb(4*i+1), eb(4*i+2), eb(4*i+3)};
  endtask

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] p);
    mem[a >> 2] = {fl, ln};
    mem[(a >> 2) + 1] = p;
  endtask

  task automatic clear_cnt();
    ncap = 0; n_txb = 0; n_txf = 0; n_babt = 0; n_rd = 0;
    first_rd = '0; last_rd = '0;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    int t = 0;
    while (q < 20 && t < WD) begin
      @(negedge clk);
      t++;
      if (mem_req || tx_valid) q = 0; else q++;
    end
    if (t >= WD) chk(1'b0, "WATCHDOG", "walk did not finish", t, WD);
  endtask

  task automatic run();
    reg_write(2'd2, 32'h0);
    wait_quiet();
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL WATCHDOG: run exceeded cycle budget");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int errs;
    int nl;
    clear_cnt();
    cyc = 0;
    init_mem();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(!mem_req && !tx_valid && !tx_last, "R11", "idle outputs after reset", {mem_req, tx_valid, tx_last}, 0);
    chk(!ev_txb && !ev_txf && !ev_babt, "R11", "events low after reset", {ev_txb, ev_txf, ev_babt}, 0);

    // R11/R8: enable clear after reset, activation ignored
    reg_write(2'd1, 32'h20);
    put_desc(32'h20, 16'hA800, 16'd3, 32'h100);
    clear_cnt();
    run();
    chk(n_rd == 0 && ncap == 0, "R8", "no activity while disabled", n_rd + ncap, 0);
    chk(mem[8] == {16'hA800, 16'd3}, "R8", "descriptor untouched while disabled", mem[8], {16'hA800, 16'd3});

    reg_write(2'd0, 32'h2);

    // table walk: single-descriptor frames (R1 R3 R4 R5 R6 R10)
    foreach (VECS[v]) begin
      init_mem();
      bp_mode = VECS[v].bp;
      reg_write(2'd1, 32'h20);
      put_desc(32'h20, 16'hA800, VECS[v].len, 32'h100 + VECS[v].off);
      clear_cnt();
      run();
      chk(ncap == VECS[v].exp_n, "R5", "streamed byte count", ncap, VECS[v].exp_n);
      errs = 0;
      for (int k = 0; k < ncap; k++) begin
        if (cap_d[k] != eb(32'h100 + VECS[v].off + k)) errs++;
        if (cap_l[k] != (k == ncap - 1)) errs++;
      end
      chk(errs == 0, "R1", "byte order and last marker", errs, 0);
      chk(n_txb == 1 && n_txf == 1, "R3", "one buffer and one frame event", n_txb * 10 + n_txf, 11);
      chk(n_babt == VECS[v].babt, "R5", "babble event count", n_babt, VECS[v].babt);
      chk(mem[8] == {16'h2800, VECS[v].len}, "R3", "written-back header", mem[8], {16'h2800, VECS[v].len});
      chk(last_rd == 32'h20, "R6", "wrap returns to ring start", last_rd, 32'h20);
    end
    bp_mode = 1'b0;

    // R7: ring start low bits cleared and pointer loaded
    init_mem();
    reg_write(2'd1, 32'h13);
    put_desc(32'h10, 16'hA800, 16'd2, 32'h140);
    clear_cnt();
    run();
    chk(first_rd == 32'h10, "R7", "first fetch at aligned ring start", first_rd, 32'h10);
    chk(ncap == 2 && cap_d[0] == eb(32'h140), "R7", "frame from aligned descriptor", ncap, 2);

    // R4/R6/R2: gather over three descriptors, wrap, stop on handed-back descriptor
    init_mem();
    bp_mode = 1'b1;
    reg_write(2'd1, 32'h40);
    put_desc(32'h40, 16'h8000, 16'd5, 32'h101);
    put_desc(32'h48, 16'h8800, 16'd3, 32'h203);
    put_desc(32'h50, 16'hA800, 16'd2, 32'h300);
    clear_cnt();
    run();
    errs = 0;
    for (int k = 0; k < 10; k++) begin
      int a;
      a = (k < 5) ? 32'h101 + k : (k < 8) ? 32'h203 + k - 5 : 32'h300 + k - 8;
      if (cap_d[k] != eb(a)) errs++;
      if (cap_l[k] != (k == 7 || k == 9)) errs++;
    end
    chk(ncap == 10, "R4", "gathered byte count", ncap, 10);
    chk(errs == 0, "R4", "gathered bytes and frame markers", errs, 0);
    chk(n_txb == 3 && n_txf == 2, "R4", "buffer/frame events", n_txb * 10 + n_txf, 32);
    chk(mem[16'h48 >> 2] == {16'h0800, 16'd3}, "R3", "middle descriptor handed back", mem[16'h48 >> 2], {16'h0800, 16'd3});
    chk(last_rd == 32'h40, "R6", "fetch after wrap descriptor", last_rd, 32'h40);
    chk(n_txb == 3 && !tx_valid && !mem_req, "R2", "walk stops at not-ready descriptor", n_txb, 3);
    bp_mode = 1'b0;

    // R5: truncation across descriptors, count restarts on next frame
    init_mem();
    reg_write(2'd1, 32'h40);
    put_desc(32'h40, 16'h8000, 16'd2000, 32'h100);
    put_desc(32'h48, 16'h8800, 16'd100, 32'h100);
    put_desc(32'h50, 16'hA800, 16'd50, 32'h200);
    clear_cnt();
    run();
    chk(ncap == 2082, "R5", "truncated plus next frame bytes", ncap, 2082);
    nl = 0;
    for (int k = 0; k < ncap; k++) if (cap_l[k]) nl++;
    chk(nl == 2 && cap_l[2031] && cap_l[2081], "R5", "markers at 2032 and 2082", nl, 2);
    chk(cap_d[2000] == eb(32'h100) && cap_d[2031] == eb(32'h100 + 31), "R5", "partial second buffer", cap_d[2031], eb(32'h100 + 31));
    chk(cap_d[2032] == eb(32'h200), "R5", "next frame first byte", cap_d[2032], eb(32'h200));
    chk(n_babt == 1 && n_txf == 2 && n_txb == 3, "R5", "events for truncated walk", n_babt * 100 + n_txf * 10 + n_txb, 123);

    // R9: per-activation descriptor cap and resume
    init_mem();
    reg_write(2'd1, 32'h80);
    for (int i = 0; i < 6; i++) put_desc(32'h80 + 8 * i, 16'h8800, 16'd1, 32'h300 + i);
    put_desc(32'hB0, 16'h0000, 16'd0, 32'h0);
    clear_cnt();
    run();
    chk(n_txb == MAXD && ncap == MAXD, "R9", "descriptors in first activation", n_txb, MAXD);
    clear_cnt();
    run();
    chk(first_rd == 32'hA0, "R9", "resume address", first_rd, 32'hA0);
    chk(n_txb == 2 && ncap == 2 && cap_d[0] == eb(32'h304), "R9", "remaining descriptors", n_txb, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule